// File: doc/BRIEF.md
# Idle-Driven Panel Refresh Rate Selector

This block picks between a panel's high and low refresh rate from frontbuffer activity. Every plane reports when rendering into the frontbuffer begins (an invalidate strobe) and when that rendering has landed in memory (a flush strobe). Page flips arrive on a separate strobe. Any of these events means the screen is busy, so the high rate is selected at once.

The block keeps one dirty bit per plane. A flush or flip that leaves every plane clean arms an idle countdown. Any later event cancels the countdown. If no event arrives for the whole timeout, the block selects the low rate. The timeout is a parameter in clock cycles. Its default, 100,000,000 cycles, equals one second at 100 MHz.

The controller is a four-state machine:
- `RS_OFF`: held at the high rate.
- `RS_HIGH`: high rate, no countdown running.
- `RS_ARMED`: high rate, countdown running.
- `RS_LOW`: low rate selected.

The transitions are:
- From any state to OFF when the block is disabled or the panel cannot run at the low rate.
- OFF to HIGH on the first cycle after the block is active again.
- HIGH to ARMED on a start request.
- ARMED to ARMED on a start request, which restarts the countdown.
- ARMED to HIGH on any other event.
- ARMED to LOW when the countdown expires.
- LOW to ARMED on a start request.
- LOW to HIGH on any other event.

A start request is a flush or flip in a cycle after which no plane is dirty. The change strobe marks each cycle in which the selected rate differs from the one before.

Top module: `rrs_switcher`

## Requirements
- R1: After reset, `rate_low` is 0 and `rate_chg` is 0.
- R2: An invalidate on plane p sets that plane's dirty bit, and a flush on plane p clears it. A flush of a clean plane leaves the other planes' dirty bits unchanged.
- R3: The countdown starts at the clock edge that samples a start request. Exactly IDLE_CYCLES further event-free edges later, `rate_low` becomes 1.
- R4: Only a flush or a flip can start the countdown, and only when no plane is dirty after that cycle's update. A flip or flush while another plane stays dirty leaves the rate high indefinitely.
- R5: Any invalidate, flush or flip sampled while `rate_low` is 1 makes `rate_low` 0 after that edge.
- R6: Any event during the countdown cancels it. If the event is itself a start request, it restarts the countdown from zero.
- R7: When `low_rate_ok` is 0, `rate_low` is 0 after that edge. The countdown cannot start again until the block has been active for one edge.
- R8: `rate_chg` is 1 for exactly the cycle after each edge at which `rate_low` changes, and is 0 otherwise.
- R9: Deasserting `enable` returns the block to the high rate and discards a running countdown. After re-enable, a new flush or flip is needed before the low rate can be reached.
- R10: An invalidate and a flush on the same plane in the same cycle leave that plane dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; 0 forces the high rate |
| low_rate_ok | input | 1 | Panel can run at the low rate |
| plane_inval | input | NUM_PLANES | Per-plane rendering-start strobe |
| plane_flush | input | NUM_PLANES | Per-plane rendering-done strobe |
| flip | input | 1 | Page flip strobe |
| rate_low | output | 1 | 1 selects the low refresh rate |
| rate_chg | output | 1 | One-cycle pulse on each change of `rate_low` |

## Verification
Directed sequences separate the cases that decide whether the countdown starts:
- A flush of the only dirty plane.
- A flush of a clean plane while another plane is dirty.
- A flip with a dirty plane.
- Invalidate and flush together on one plane.

A mistake in the dirty bookkeeping shows up in only one of these cases. Restart, disable and capability-loss sequences separate a cancelled countdown from one that keeps running. The exact expiry cycle, checked one edge early and at the edge itself, catches off-by-one errors in the timer. Sparse random events with a short timeout then mix long quiet gaps with bursts of events. Each cycle is compared with a bench model.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        RS_OFF   = 2'd0,
        RS_HIGH  = 2'd1,
        RS_ARMED = 2'd2,
        RS_LOW   = 2'd3
    } rrs_state_e;
endpackage

// File: rtl/rrs_plane_tracker.sv
module rrs_plane_tracker #(
    parameter int NUM_PLANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PLANES-1:0] plane_inval,
    input  logic [NUM_PLANES-1:0] plane_flush,
    input  logic                  flip,
    output logic [NUM_PLANES-1:0] dirty_q,
    output logic                  any_event,
    output logic                  start_req
);
    logic [NUM_PLANES-1:0] dirty_d;

    // One dirty bit per plane; invalidate has priority over a same-cycle flush.
    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        assign dirty_d[p] = plane_inval[p] | (dirty_q[p] & ~plane_flush[p]);

        always_ff @(posedge clk) begin
            if (!rst_n) dirty_q[p] <= 1'b0;
            else        dirty_q[p] <= dirty_d[p];
        end
    end

    always_comb begin
        any_event = (|plane_inval) | (|plane_flush) | flip;
        start_req = ((|plane_flush) | flip) & (dirty_d == '0);
    end
endmodule

// File: rtl/rrs_idle_timer.sv
module rrs_idle_timer #(
    parameter int IDLE_CYCLES = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/rrs_ctrl_fsm.sv
module rrs_ctrl_fsm
    import rrs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       any_event,
    input  logic       start_req,
    input  logic       expired,
    output logic       tmr_clear,
    output rrs_state_e state_q,
    output logic       rate_low,
    output logic       rate_chg
);
    rrs_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = RS_OFF;
        end else begin
            unique case (state_q)
                RS_OFF:   state_d = RS_HIGH;
                RS_HIGH:  if (start_req) state_d = RS_ARMED;
                RS_ARMED: begin
                    if (start_req)      state_d = RS_ARMED;
                    else if (any_event) state_d = RS_HIGH;
                    else if (expired)   state_d = RS_LOW;
                end
                RS_LOW: begin
                    if (start_req)      state_d = RS_ARMED;
                    else if (any_event) state_d = RS_HIGH;
                end
                default:  state_d = RS_OFF;
            endcase
        end
    end

    // The countdown only runs through event-free cycles in the armed state.
    assign tmr_clear = (state_q != RS_ARMED) | any_event;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_low <= 1'b0;
            rate_chg <= 1'b0;
        end else begin
            rate_low <= (state_d == RS_LOW);
            rate_chg <= (state_d == RS_LOW) != rate_low;
        end
    end
endmodule

// File: rtl/rrs_switcher.sv
module rrs_switcher
    import rrs_pkg::*;
#(
    parameter int NUM_PLANES  = 4,
    parameter int IDLE_CYCLES = 100_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  low_rate_ok,
    input  logic [NUM_PLANES-1:0] plane_inval,
    input  logic [NUM_PLANES-1:0] plane_flush,
    input  logic                  flip,
    output logic                  rate_low,
    output logic                  rate_chg
);
    logic [NUM_PLANES-1:0] dirty_q;
    logic                  any_event;
    logic                  start_req;
    logic                  expired;
    logic                  tmr_clear;
    rrs_state_e            state_q;

    rrs_plane_tracker #(.NUM_PLANES(NUM_PLANES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .plane_inval (plane_inval),
        .plane_flush (plane_flush),
        .flip        (flip),
        .dirty_q     (dirty_q),
        .any_event   (any_event),
        .start_req   (start_req)
    );

    rrs_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .expired (expired)
    );

    rrs_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (enable & low_rate_ok),
        .any_event (any_event),
        .start_req (start_req),
        .expired   (expired),
        .tmr_clear (tmr_clear),
        .state_q   (state_q),
        .rate_low  (rate_low),
        .rate_chg  (rate_chg)
    );
endmodule

// File: rtl/rrs_switcher_chk.sv
module rrs_switcher_chk #(
    parameter int NUM_PLANES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  low_rate_ok,
    input logic [NUM_PLANES-1:0] plane_inval,
    input logic [NUM_PLANES-1:0] plane_flush,
    input logic                  flip,
    input logic [NUM_PLANES-1:0] dirty_q,
    input logic                  rate_low,
    input logic                  rate_chg
);
    logic evt;
    assign evt = (|plane_inval) | (|plane_flush) | flip;

    p_busy_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_low && evt) |=> !rate_low);

    p_incapable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !low_rate_ok |=> !rate_low);

    p_disable_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rate_low);

    p_strobe_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rate_chg |-> (rate_low != $past(rate_low)));

    p_low_needs_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_low) |-> ($past(dirty_q) == '0));

    p_low_after_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_low) |-> !$past(evt));
endmodule

bind rrs_switcher rrs_switcher_chk #(.NUM_PLANES(NUM_PLANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .low_rate_ok (low_rate_ok),
    .plane_inval (plane_inval),
    .plane_flush (plane_flush),
    .flip        (flip),
    .dirty_q     (dirty_q),
    .rate_low    (rate_low),
    .rate_chg    (rate_chg)
);

// File: tb/tb_rrs_switcher.sv
module tb_rrs_switcher;
    localparam int NP = 4;
    localparam int N  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          low_rate_ok = 1'b0;
    logic [NP-1:0] plane_inval = '0;
    logic [NP-1:0] plane_flush = '0;
    logic          flip = 1'b0;
    logic          rate_low;
    logic          rate_chg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model: mode 0 off, 1 high, 2 armed, 3 low
    int            m_mode = 0;
    int            m_cnt = 0;
    logic [NP-1:0] m_dirty = '0;
    bit            m_low = 1'b0;
    bit            m_chg = 1'b0;

    always #5 clk = ~clk;

    rrs_switcher #(.NUM_PLANES(NP), .IDLE_CYCLES(N)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .low_rate_ok(low_rate_ok),
        .plane_inval(plane_inval), .plane_flush(plane_flush), .flip(flip),
        .rate_low(rate_low), .rate_chg(rate_chg)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_mode(input int mode, input bit act, input bit evt,
                                     input bit start, input bit exp_t);
        if (!act) return 0;
        case (mode)
            0: return 1;
            1: return start ? 2 : 1;
            2: return start ? 2 : (evt ? 1 : (exp_t ? 3 : 2));
            default: return start ? 2 : (evt ? 1 : 3);
        endcase
    endfunction

    task automatic model_edge();
        logic [NP-1:0] dn;
        bit evt, start, nl;
        int nm;
        dn    = plane_inval | (m_dirty & ~plane_flush);
        evt   = (|plane_inval) | (|plane_flush) | flip;
        start = ((|plane_flush) | flip) && (dn == '0);
        nm    = next_mode(m_mode, enable && low_rate_ok, evt, start, m_cnt == N - 1);
        if (m_mode != 2 || evt) m_cnt = 0;
        else if (m_cnt != N - 1) m_cnt = m_cnt + 1;
        nl      = (nm == 3);
        m_chg   = (nl != m_low);
        m_low   = nl;
        m_mode  = nm;
        m_dirty = dn;
    endtask

    // one clock: inputs already set; update model at edge, compare after
    task automatic step(input logic [NP-1:0] inv, input logic [NP-1:0] fl, input logic fp);
        plane_inval = inv;
        plane_flush = fl;
        flip = fp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R3 model rate_low", rate_low, m_low);
        check("R8 model rate_chg", rate_chg, m_chg);
        plane_inval = '0;
        plane_flush = '0;
        flip = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset rate_low", rate_low, 1'b0);
        check("R1 reset rate_chg", rate_chg, 1'b0);
        rst_n = 1'b1;
        enable = 1'b1;
        low_rate_ok = 1'b1;
        idle(3);

        // R3 / R8: flush starts countdown; low exactly N edges later
        step('0, 4'b0001, 1'b0);
        idle(N - 1);
        check("R3 low one edge early", rate_low, 1'b0);
        idle(1);
        check("R3 low at expiry", rate_low, 1'b1);
        check("R8 strobe on rise", rate_chg, 1'b1);
        idle(1);
        check("R8 strobe one cycle", rate_chg, 1'b0);
        check("R3 low held", rate_low, 1'b1);

        // R5: invalidate while low returns to high
        step(4'b0010, '0, 1'b0);
        check("R5 busy forces high", rate_low, 1'b0);
        check("R8 strobe on fall", rate_chg, 1'b1);

        // R2 / R4: flush of other plane and flip while plane 1 dirty do not arm
        step('0, 4'b0100, 1'b0);
        idle(N + 2);
        check("R2 other flush keeps dirty", rate_low, 1'b0);
        step('0, '0, 1'b1);
        idle(N + 2);
        check("R4 flip with dirty plane", rate_low, 1'b0);
        step('0, 4'b0010, 1'b0);
        idle(N);
        check("R2 matching flush arms", rate_low, 1'b1);

        // R6: restart during countdown
        step('0, '0, 1'b1);
        check("R5 flip leaves low", rate_low, 1'b0);
        idle(N / 2);
        step('0, '0, 1'b1);
        idle(N - 1);
        check("R6 restart delays expiry", rate_low, 1'b0);
        idle(1);
        check("R6 expiry after restart", rate_low, 1'b1);

        // R10: same-cycle invalidate and flush keep plane dirty
        step(4'b1000, 4'b1000, 1'b0);
        step('0, '0, 1'b1);
        idle(N + 2);
        check("R10 plane stays dirty", rate_low, 1'b0);
        step('0, 4'b1000, 1'b0);
        idle(N);
        check("R10 later flush arms", rate_low, 1'b1);

        // R7: losing low-rate capability
        low_rate_ok = 1'b0;
        idle(1);
        check("R7 capability lost", rate_low, 1'b0);
        check("R8 strobe on capability loss", rate_chg, 1'b1);
        step('0, 4'b0001, 1'b0);
        idle(N + 3);
        check("R7 never low", rate_low, 1'b0);
        low_rate_ok = 1'b1;
        idle(2);

        // R9: disable cancels a running countdown
        step('0, '0, 1'b1);
        idle(N / 2);
        enable = 1'b0;
        idle(1);
        enable = 1'b1;
        idle(N + 3);
        check("R9 countdown discarded", rate_low, 1'b0);
        step('0, '0, 1'b1);
        idle(N);
        check("R9 new flip arms", rate_low, 1'b1);

        // random phase with sparse events
        for (int i = 0; i < 4000; i++) begin
            logic [NP-1:0] inv, fl;
            logic fp;
            for (int p = 0; p < NP; p++) begin
                inv[p] = ($urandom % 100) < 2;
                fl[p]  = ($urandom % 100) < 3;
            end
            fp = ($urandom % 100) < 2;
            enable      = ($urandom % 200) != 0;
            low_rate_ok = ($urandom % 300) != 0;
            if (($urandom % 8) == 0) begin
                inv = '0; fl = '0; fp = 1'b0;
            end
            step(inv, fl, fp);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule